// File: doc/BRIEF.md
# Omega Multistage Interconnection Network

This block connects eight requesters (typically processors) to eight targets (typically memory modules) through three stages of two-by-two exchange switches. A perfect shuffle of the line indices (the 3-bit index rotated left by one place) feeds each stage. Every requester may present one single-cycle item per clock: a destination tag and a data word. Each item finds its own way through the stages. Stage 0 steers on the most significant tag bit, stage 1 on the middle bit and stage 2 on the least significant bit. A tag bit of 0 sends the item to the upper output of its switch, and a 1 sends it to the lower output. Each source and destination pair therefore has exactly one path.

Two items can need the same output of one switch. In that case the item on the switch's upper input goes through and the other is dropped for that cycle. Some destination sets therefore cannot be served together even when every destination is distinct, for example targets 000 and 001 requested by sources 0 and 4. The routing fabric is purely combinational. A single register stage at the outputs holds the delivered items, so an item accepted in cycle t appears at its target in cycle t+1 together with the index of the source that sent it.

Request side: `src_valid` is the valid signal. `src_busy` acts as an inverted ready for the same cycle: an item is accepted at a clock edge only when `src_valid` is high and `src_busy` is low. A busy source keeps its item and tries again on a later cycle. The target side has no back-pressure: a delivered item is shown for exactly one cycle and must be taken.

Top module: `omega_net`

## Requirements
- R1: A request with `src_valid` high and `src_busy` low in cycle t appears in cycle t+1 at target d, where d is its 3-bit tag. In that cycle `dst_valid[d]` is 1, `dst_data` slot d holds its data word and `dst_src` slot d holds the source index.
- R2: Slot k of `src_dest`, `src_data`, `dst_src` and `dst_data` is the bit field starting at k times its width. An item from any source reaches the target named by its tag. Stage 0 uses tag bit 2, stage 1 bit 1 and stage 2 bit 0. A 0 selects the upper switch output and a 1 the lower. Permutations that do not collide at any switch, such as the identity, XOR by a constant and cyclic shift, are delivered in full with no busy source.
- R3: A lone valid request is never blocked, whatever its source and tag.
- R4: When two items need the same switch output, the item on the switch's upper input (the even line after the shuffle) wins. The other source sees `src_busy` high in the same cycle. Example: source 0 to target 0 and source 4 to target 1 give busy mask 8'h10, and so do source 0 to target 1 and source 4 to target 0.
- R5: `src_busy[k]` is never high while `src_valid[k]` is low.
- R6: The number of high `dst_valid` bits in cycle t+1 equals the number of requests accepted in cycle t. No item is duplicated or invented.
- R7: While `rst_n` is low, every `dst_valid` bit is 0. `rst_n` acts asynchronously and is active low.
- R8: If all eight sources target the same destination, only source 0 is delivered and the busy mask is 8'hFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 8 | Request present, one bit per source |
| src_dest | input | 24 | 3-bit destination tag per source |
| src_data | input | 64 | 8-bit data word per source |
| src_busy | output | 8 | Request blocked this cycle (inverted ready) |
| dst_valid | output | 8 | Delivered item present, one bit per target |
| dst_data | output | 64 | 8-bit delivered data per target |
| dst_src | output | 24 | 3-bit source index of the delivered item per target |

## Verification
The bench targets switch collisions. Two cases check which input wins. In the first, source 0 and source 4 share a switch in stage 0 and their tags differ only in the last bit. In the second, their tags are swapped. A design that favoured the lower input, or that looked at the wrong tag bit, would mark source 0 busy or deliver to the wrong target. The all-to-one pattern checks that losers are dropped at later stages, not only at the first. A fabric that passed both contenders on, or that lost track of the winner, would show more than one valid target or a wrong source index. Collision-free permutations and randomised patterns are compared against a routing model inside the bench. A wrong shuffle wiring or a reversed stage order would then send data to the wrong target. Reset is also applied in the middle of traffic, which catches registered outputs that survive it.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle: rotate an lg-bit line index left by one place.
  function automatic int shuffle_pos(int pos, int lg);
    return ((pos << 1) | (pos >> (lg - 1))) & ((1 << lg) - 1);
  endfunction

  // Field offsets inside a line word {src, tag, data}.
  function automatic int tag_lsb(int data_w);
    return data_w;
  endfunction

  function automatic int src_lsb(int data_w, int lg);
    return data_w + lg;
  endfunction

endpackage

// File: rtl/omega_switch2.sv
module omega_switch2 #(
  parameter int W   = 14,
  parameter int SEL = 8
) (
  input  logic         up_v,
  input  logic [W-1:0] up_w,
  input  logic         lo_v,
  input  logic [W-1:0] lo_w,
  output logic         o0_v,
  output logic [W-1:0] o0_w,
  output logic         o1_v,
  output logic [W-1:0] o1_w
);

  logic up_to_lo, lo_to_lo;

  assign up_to_lo = up_w[SEL];
  assign lo_to_lo = lo_w[SEL];

  // Upper output: the upper input has precedence.
  always_comb begin
    o0_v = 1'b0;
    o0_w = up_w;
    if (up_v && !up_to_lo) begin
      o0_v = 1'b1;
      o0_w = up_w;
    end else if (lo_v && !lo_to_lo) begin
      o0_v = 1'b1;
      o0_w = lo_w;
    end
  end

  // Lower output: the upper input has precedence.
  always_comb begin
    o1_v = 1'b0;
    o1_w = lo_w;
    if (up_v && up_to_lo) begin
      o1_v = 1'b1;
      o1_w = up_w;
    end else if (lo_v && lo_to_lo) begin
      o1_v = 1'b1;
      o1_w = lo_w;
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int LOG     = 3,
  parameter int W       = 14,
  parameter int TAG_BIT = 8,
  localparam int N      = 1 << LOG
) (
  input  logic [N-1:0]   in_v,
  input  logic [N*W-1:0] in_w,
  output logic [N-1:0]   out_v,
  output logic [N*W-1:0] out_w
);

  logic [N-1:0]   sh_v;
  logic [N*W-1:0] sh_w;

  // Perfect-shuffle wiring ahead of the switch column.
  for (genvar p = 0; p < N; p++) begin : g_shuf
    localparam int Q = omega_pkg::shuffle_pos(p, LOG);
    assign sh_v[Q]         = in_v[p];
    assign sh_w[Q*W +: W]  = in_w[p*W +: W];
  end

  // Column of two-by-two exchange switches.
  for (genvar s = 0; s < N/2; s++) begin : g_sw
    omega_switch2 #(.W(W), .SEL(TAG_BIT)) u_sw (
      .up_v (sh_v[2*s]),
      .up_w (sh_w[(2*s)*W +: W]),
      .lo_v (sh_v[2*s+1]),
      .lo_w (sh_w[(2*s+1)*W +: W]),
      .o0_v (out_v[2*s]),
      .o0_w (out_w[(2*s)*W +: W]),
      .o1_v (out_v[2*s+1]),
      .o1_w (out_w[(2*s+1)*W +: W])
    );
  end

endmodule

// File: rtl/omega_net.sv
module omega_net #(
  parameter int LOG_PORTS = 3,
  parameter int DATA_W    = 8,
  localparam int N        = 1 << LOG_PORTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          src_valid,
  input  logic [N*LOG_PORTS-1:0] src_dest,
  input  logic [N*DATA_W-1:0]   src_data,
  output logic [N-1:0]          src_busy,
  output logic [N-1:0]          dst_valid,
  output logic [N*DATA_W-1:0]   dst_data,
  output logic [N*LOG_PORTS-1:0] dst_src
);

  localparam int W    = DATA_W + 2*LOG_PORTS;
  localparam int TLSB = omega_pkg::tag_lsb(DATA_W);
  localparam int SLSB = omega_pkg::src_lsb(DATA_W, LOG_PORTS);

  logic [N-1:0]   lv [LOG_PORTS+1];
  logic [N*W-1:0] lw [LOG_PORTS+1];

  // Build line words {source index, tag, data}.
  for (genvar i = 0; i < N; i++) begin : g_in
    assign lv[0][i]         = src_valid[i];
    assign lw[0][i*W +: W]  = {LOG_PORTS'(i),
                               src_dest[i*LOG_PORTS +: LOG_PORTS],
                               src_data[i*DATA_W +: DATA_W]};
  end

  // Stage k steers on tag bit LOG_PORTS-1-k (most significant first).
  for (genvar k = 0; k < LOG_PORTS; k++) begin : g_stage
    omega_stage #(.LOG(LOG_PORTS), .W(W), .TAG_BIT(TLSB + LOG_PORTS - 1 - k)) u_stage (
      .in_v  (lv[k]),
      .in_w  (lw[k]),
      .out_v (lv[k+1]),
      .out_w (lw[k+1])
    );
  end

  // Sources that reached an output this cycle.
  logic [N-1:0]           delivered;
  logic [LOG_PORTS-1:0]   unused_tags;

  always_comb begin
    delivered   = '0;
    unused_tags = '0;
    for (int j = 0; j < N; j++) begin
      unused_tags = unused_tags ^ lw[LOG_PORTS][j*W + TLSB +: LOG_PORTS];
      if (lv[LOG_PORTS][j])
        delivered[lw[LOG_PORTS][j*W + SLSB +: LOG_PORTS]] = 1'b1;
    end
  end

  assign src_busy = src_valid & ~delivered;

  // Registered output stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_valid <= '0;
      dst_data  <= '0;
      dst_src   <= '0;
    end else begin
      dst_valid <= lv[LOG_PORTS];
      for (int j = 0; j < N; j++) begin
        dst_data[j*DATA_W +: DATA_W]       <= lw[LOG_PORTS][j*W +: DATA_W];
        dst_src[j*LOG_PORTS +: LOG_PORTS]  <= lw[LOG_PORTS][j*W + SLSB +: LOG_PORTS];
      end
    end
  end

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
  parameter int LOG_PORTS = 3,
  parameter int DATA_W    = 8,
  localparam int N        = 1 << LOG_PORTS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N-1:0]           src_valid,
  input logic [N*LOG_PORTS-1:0] src_dest,
  input logic [N*DATA_W-1:0]    src_data,
  input logic [N-1:0]           src_busy,
  input logic [N-1:0]           dst_valid,
  input logic [N*DATA_W-1:0]    dst_data,
  input logic [N*LOG_PORTS-1:0] dst_src
);

  logic [N-1:0]           pv, pb;
  logic [N*LOG_PORTS-1:0] pd;
  logic [N*DATA_W-1:0]    pdat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0; pb <= '0; pd <= '0; pdat <= '0;
    end else begin
      pv <= src_valid; pb <= src_busy; pd <= src_dest; pdat <= src_data;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [LOG_PORTS-1:0] di;
    assign di = pd[i*LOG_PORTS +: LOG_PORTS];

    // R1: accepted item shows up at its target next cycle
    a_r1_delivery: assert property (@(posedge clk) disable iff (!rst_n)
      (pv[i] && !pb[i]) |-> (dst_valid[di] &&
        dst_src[di*LOG_PORTS +: LOG_PORTS] == LOG_PORTS'(i) &&
        dst_data[di*DATA_W +: DATA_W] == pdat[i*DATA_W +: DATA_W]));

    // R5: idle source never flagged busy
    a_r5_idle_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid[i] |-> !src_busy[i]);
  end

  for (genvar j = 0; j < N; j++) begin : g_dst
    logic [LOG_PORTS-1:0] sj;
    assign sj = dst_src[j*LOG_PORTS +: LOG_PORTS];

    // R2: delivered item really was addressed to this target
    a_r2_origin: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid[j] |-> (pv[sj] && pd[sj*LOG_PORTS +: LOG_PORTS] == LOG_PORTS'(j)));
  end

  // R3: a lone request is never blocked
  a_r3_lone: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(src_valid) == 1) |-> (src_busy == '0));

  // R6: outputs match accepted requests one for one
  a_r6_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dst_valid) == $countones(pv & ~pb));

endmodule

bind omega_net omega_net_chk #(.LOG_PORTS(LOG_PORTS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/omega_net_tb_top.sv
`timescale 1ns/1ps
module omega_net_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_valid, src_busy, dst_valid;
  logic [23:0] src_dest, dst_src;
  logic [63:0] src_data, dst_data;

  always #5 clk = ~clk;

  omega_net dut_i (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_dest(src_dest),
    .src_data(src_data), .src_busy(src_busy), .dst_valid(dst_valid),
    .dst_data(dst_data), .dst_src(dst_src)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [23:0] pk(int a0, int a1, int a2, int a3,
                                     int a4, int a5, int a6, int a7);
    return {3'(a7), 3'(a6), 3'(a5), 3'(a4), 3'(a3), 3'(a2), 3'(a1), 3'(a0)};
  endfunction

  // {valid mask, tags, hand-derived busy mask}
  localparam logic [39:0] VEC [8] = '{
    {8'hFF, pk(0,1,2,3,4,5,6,7), 8'h00},   // R2 identity
    {8'h11, pk(0,0,0,0,1,0,0,0), 8'h10},   // R4 src0->0, src4->1
    {8'hFF, pk(0,0,0,0,0,0,0,0), 8'hFE},   // R8 all to target 0
    {8'h20, pk(0,0,0,0,0,3,0,0), 8'h00},   // R3 lone request
    {8'hFF, pk(7,6,5,4,3,2,1,0), 8'h00},   // R2 xor by 7
    {8'hFF, pk(1,2,3,4,5,6,7,0), 8'h00},   // R2 cyclic shift
    {8'h00, pk(5,5,5,5,5,5,5,5), 8'h00},   // R5 R6 nothing valid
    {8'h11, pk(1,0,0,0,0,0,0,0), 8'h10}    // R4 src0->1, src4->0
  };

  // Reference routing model: walk lines by position, first come wins.
  int         m_src [8];
  logic [7:0] m_valid, m_busy;

  task automatic run_model(input logic [7:0] v, input logic [23:0] d);
    int occ [8];
    int sh  [8];
    int nxt [8];
    logic [7:0] got;
    for (int p = 0; p < 8; p++) occ[p] = v[p] ? p : -1;
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p < 8; p++) sh[((p << 1) | (p >> 2)) & 7] = occ[p];
      for (int p = 0; p < 8; p++) nxt[p] = -1;
      for (int q = 0; q < 8; q++) begin
        if (sh[q] >= 0) begin
          int t;
          t = (q & 6) | int'(d[sh[q]*3 + (2 - k)]);
          if (nxt[t] < 0) nxt[t] = sh[q];
        end
      end
      for (int p = 0; p < 8; p++) occ[p] = nxt[p];
    end
    got = '0;
    for (int j = 0; j < 8; j++) begin
      m_valid[j] = (occ[j] >= 0);
      m_src[j]   = occ[j];
      if (occ[j] >= 0) got[occ[j]] = 1'b1;
    end
    m_busy = v & ~got;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v, input logic [23:0] d, input logic [3:0] tag,
                       input bit use_hand, input logic [7:0] hand_busy);
    @(negedge clk);
    src_valid = v;
    src_dest  = d;
    for (int i = 0; i < 8; i++) src_data[i*8 +: 8] = {tag, 4'(i)};
    run_model(v, d);
    #1;
    if (use_hand) chk(src_busy == hand_busy, "R4", "busy mask (hand)", 64'(src_busy), 64'(hand_busy));
    chk(src_busy == m_busy, "R4", "busy mask (model)", 64'(src_busy), 64'(m_busy));
    @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      chk(dst_valid[j] == m_valid[j], "R6", $sformatf("dst_valid[%0d]", j),
          64'(dst_valid[j]), 64'(m_valid[j]));
      if (m_valid[j]) begin
        chk(dst_src[j*3 +: 3] == 3'(m_src[j]) && dst_data[j*8 +: 8] == {tag, 4'(m_src[j])},
            "R1", $sformatf("target %0d src/data", j),
            64'({dst_src[j*3 +: 3], dst_data[j*8 +: 8]}),
            64'({3'(m_src[j]), tag, 4'(m_src[j])}));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    src_valid = 8'hFF;
    src_dest  = pk(0,1,2,3,4,5,6,7);
    src_data  = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dst_valid == 8'h00, "R7", "dst_valid in reset", 64'(dst_valid), 64'h0);
    rst_n = 1'b1;

    for (int n = 0; n < 8; n++)
      apply(VEC[n][39:32], VEC[n][31:8], 4'(n), 1'b1, VEC[n][7:0]);

    lfsr = 32'h1D2C_3B4A;
    for (int n = 0; n < 150; n++) begin
      apply(lfsr[7:0], lfsr[31:8], lfsr[11:8], 1'b0, 8'h00);   // R2 R4 random mix
      for (int s = 0; s < 8; s++)
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end

    // R7: reset during traffic clears delivered items
    apply(8'hFF, pk(0,1,2,3,4,5,6,7), 4'hC, 1'b0, 8'h00);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dst_valid == 8'h00, "R7", "dst_valid after mid-run reset", 64'(dst_valid), 64'h0);
    @(negedge clk);
    chk(dst_valid == 8'h00, "R7", "dst_valid held in reset", 64'(dst_valid), 64'h0);
    rst_n = 1'b1;
    apply(8'h01, pk(6,0,0,0,0,0,0,0), 4'h3, 1'b1, 8'h00);   // R3 after reset

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule